// File: doc/BRIEF.md
# Tile Shape Configuration Unit

This unit keeps the shape settings for a bank of two-dimensional tile registers inside a matrix coprocessor. Software-facing logic streams a 512-bit configuration image into it as sixteen 32-bit beats. The unit checks every beat as it arrives and collects the fields it needs in a staging copy. When the last beat is in, it decides in one extra cycle what to do with the image. It can latch the image, return to the init state, or reject the image with a one-cycle fault pulse. The active copy drives, for every tile, a row count and a byte width per row. It also drives a configured flag, and a one-cycle strobe that tells the tile storage to clear all tile data.

A read request streams the active image back as sixteen beats in the same layout. A release command returns the unit to the init state from any state and takes priority over everything else.

The controller has four states:
- IDLE: waiting. A write beat moves it to LOAD, and a read request moves it to READ.
- LOAD: counting incoming beats. The sixteenth beat moves it to COMMIT.
- COMMIT: one cycle in which the image is latched, taken as init, or rejected. It then returns to IDLE.
- READ: sixteen output beats, then back to IDLE.

Release forces IDLE from every state.

Top module: `tile_cfg_unit`

## Requirements
- R1: After reset, `cfg_valid_o`, `zero_tiles_o`, `fault_o` and `rd_valid_o` are 0, and every tile shape output is 0.
- R2: Image layout and latching. Byte b of the image is carried in beat b/4, bits 8*(b%4)+7 down to 8*(b%4). Byte 0 is the palette. Tile t has a 16-bit little-endian bytes-per-row field at bytes 16+2t and 17+2t, and an 8-bit row count at byte 48+t. Take E as the edge that samples the final beat. A valid palette-1 image drives the shapes of every tile and sets `cfg_valid_o` to 1 after edge E+1.
- R3: A palette-0 image sets `cfg_valid_o` to 0 and all shapes to 0 after edge E+1. `zero_tiles_o` is high for that one cycle, and `fault_o` stays low.
- R4: `rel_i` sampled high, in any state, sets `cfg_valid_o` to 0, sets the shapes to 0 and pulses `zero_tiles_o` after the same edge. It abandons a partial load, and the next beat is taken as beat 0.
- R5: A palette value above 1 pulses `fault_o` for one cycle after edge E+1. The configured flag and all shapes keep their previous values.
- R6: With palette 1, any row count above 16 or any bytes-per-row value above 64 faults, as in R5. The boundary values 16 and 64 are accepted. The whole 16-bit width field is compared.
- R7: With palette 1, any nonzero byte among bytes 1 to 15 faults, as in R5.
- R8: A read request in IDLE gives `rd_valid_o` high for exactly 16 cycles, starting after the sampling edge. The beats carry the active image in R2 layout: palette 1, reserved bytes 0, and fields zero-extended.
- R9: While unconfigured, every read-back beat is 0.
- R10: Idle cycles between write beats do not change the result. A read request sampled during LOAD or COMMIT is ignored.
- R11: A palette-0 image is taken as init even when its other fields are out of range. No fault is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid_i | input | 1 | Write beat valid |
| wr_data_i | input | 32 | Write beat data |
| rd_req_i | input | 1 | Start a read-back of the image |
| rel_i | input | 1 | Release command: return to init |
| rd_valid_o | output | 1 | Read-back beat valid |
| rd_data_o | output | 32 | Read-back beat data |
| cfg_valid_o | output | 1 | Tiles are configured |
| zero_tiles_o | output | 1 | One-cycle strobe: clear all tile data |
| fault_o | output | 1 | One-cycle pulse: image rejected |
| tile_rows_o | output | N_TILES*5 | Row count per tile, tile t at bits [5t+4:5t] |
| tile_bpr_o | output | N_TILES*7 | Bytes per row per tile, tile t at bits [7t+6:7t] |

## Verification
The assertions assume that the driver starts a read only from IDLE. They also assume that the driver does not send write beats during COMMIT or READ, because such beats are dropped and would shift the image. The stimulus keeps to this by finishing each load or read before issuing the next operation. The one exception is during LOAD, where read requests are raised on purpose to show that they are ignored. Release is applied both while idle and in the middle of a load, and the run then continues with a clean image. This shows that the beat counter restarts at beat 0.

// File: rtl/tcfg_pkg.sv
package tcfg_pkg;
    localparam int IMG_BEATS  = 16;
    localparam int BEAT_W     = 32;
    localparam int SLOT_CNT   = 16;
    localparam int BEAT_IDX_W = $clog2(IMG_BEATS);
    localparam int BPR_BEAT0  = 4;
    localparam int ROW_BEAT0  = 12;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_COMMIT,
        ST_READ
    } tcfg_state_e;
endpackage

// File: rtl/tcfg_beat_check.sv
module tcfg_beat_check
    import tcfg_pkg::*;
#(
    parameter int N_TILES = 16,
    parameter int ROW_MAX = 16,
    parameter int BPR_MAX = 64
) (
    input  logic [BEAT_IDX_W-1:0] beat_idx,
    input  logic [BEAT_W-1:0]     beat_data,
    output logic                  pal_zero,
    output logic                  pal_bad,
    output logic                  field_bad
);
    always_comb begin
        pal_zero  = 1'b0;
        pal_bad   = 1'b0;
        field_bad = 1'b0;
        if (int'(beat_idx) == 0) begin
            pal_zero  = (beat_data[7:0] == 8'd0);
            pal_bad   = (beat_data[7:0] > 8'd1);
            field_bad = (beat_data[31:8] != 24'd0);
        end else if (int'(beat_idx) < BPR_BEAT0) begin
            field_bad = (beat_data != '0);
        end else if (int'(beat_idx) < ROW_BEAT0) begin
            for (int h = 0; h < 2; h++) begin
                if (int'(beat_data[16*h +: 16]) > BPR_MAX) field_bad = 1'b1;
                if (((int'(beat_idx) - BPR_BEAT0) * 2 + h >= N_TILES) &&
                    (beat_data[16*h +: 16] != 16'd0)) field_bad = 1'b1;
            end
        end else begin
            for (int b = 0; b < 4; b++) begin
                if (int'(beat_data[8*b +: 8]) > ROW_MAX) field_bad = 1'b1;
                if (((int'(beat_idx) - ROW_BEAT0) * 4 + b >= N_TILES) &&
                    (beat_data[8*b +: 8] != 8'd0)) field_bad = 1'b1;
            end
        end
    end
endmodule

// File: rtl/tcfg_shape_store.sv
module tcfg_shape_store
    import tcfg_pkg::*;
#(
    parameter int N_TILES = 16,
    parameter int ROW_MAX = 16,
    parameter int BPR_MAX = 64,
    parameter int ROW_W   = 5,
    parameter int BPR_W   = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     stage_en,
    input  logic [BEAT_IDX_W-1:0]    beat_idx,
    input  logic [BEAT_W-1:0]        beat_data,
    input  logic                     commit_en,
    input  logic                     clear_en,
    output logic [N_TILES*ROW_W-1:0] rows_flat,
    output logic [N_TILES*BPR_W-1:0] bpr_flat
);
    for (genvar t = 0; t < N_TILES; t++) begin : g_tile
        localparam int RB   = ROW_BEAT0 + t / 4;
        localparam int RLSB = 8 * (t % 4);
        localparam int BB   = BPR_BEAT0 + t / 2;
        localparam int BLSB = 16 * (t % 2);

        logic [ROW_W-1:0] stg_rows, act_rows;
        logic [BPR_W-1:0] stg_bpr, act_bpr;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg_rows <= '0;
                stg_bpr  <= '0;
            end else if (stage_en) begin
                if (beat_idx == BEAT_IDX_W'(RB)) stg_rows <= beat_data[RLSB +: ROW_W];
                if (beat_idx == BEAT_IDX_W'(BB)) stg_bpr  <= beat_data[BLSB +: BPR_W];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                act_rows <= '0;
                act_bpr  <= '0;
            end else if (clear_en) begin
                act_rows <= '0;
                act_bpr  <= '0;
            end else if (commit_en) begin
                act_rows <= stg_rows;
                act_bpr  <= stg_bpr;
            end
        end

        assign rows_flat[t*ROW_W +: ROW_W] = act_rows;
        assign bpr_flat[t*BPR_W +: BPR_W]  = act_bpr;

        // R6: only in-range shapes ever reach the active copy
        p_rows_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
            int'(act_rows) <= ROW_MAX);
        p_bpr_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
            int'(act_bpr) <= BPR_MAX);
    end
endmodule

// File: rtl/tile_cfg_unit.sv
module tile_cfg_unit
    import tcfg_pkg::*;
#(
    parameter int N_TILES = 16,
    parameter int ROW_MAX = 16,
    parameter int BPR_MAX = 64,
    localparam int ROW_W  = $clog2(ROW_MAX + 1),
    localparam int BPR_W  = $clog2(BPR_MAX + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_valid_i,
    input  logic [BEAT_W-1:0]        wr_data_i,
    input  logic                     rd_req_i,
    input  logic                     rel_i,
    output logic                     rd_valid_o,
    output logic [BEAT_W-1:0]        rd_data_o,
    output logic                     cfg_valid_o,
    output logic                     zero_tiles_o,
    output logic                     fault_o,
    output logic [N_TILES*ROW_W-1:0] tile_rows_o,
    output logic [N_TILES*BPR_W-1:0] tile_bpr_o
);
    localparam logic [BEAT_IDX_W-1:0] LAST_BEAT = BEAT_IDX_W'(IMG_BEATS - 1);

    tcfg_state_e           state_q, state_d;
    logic [BEAT_IDX_W-1:0] cnt_q, cnt_d;
    logic                  acc_bad_q, acc_pzero_q, acc_pbad_q;
    logic                  beat_pzero, beat_pbad, beat_bad;
    logic                  beat_take, do_init, do_fault, do_latch, in_commit;
    logic                  cfg_q, zero_q, fault_q;

    tcfg_beat_check #(
        .N_TILES(N_TILES), .ROW_MAX(ROW_MAX), .BPR_MAX(BPR_MAX)
    ) u_check (
        .beat_idx (cnt_q),
        .beat_data(wr_data_i),
        .pal_zero (beat_pzero),
        .pal_bad  (beat_pbad),
        .field_bad(beat_bad)
    );

    assign beat_take = wr_valid_i && !rel_i &&
                       (state_q == ST_IDLE || state_q == ST_LOAD);
    assign in_commit = (state_q == ST_COMMIT) && !rel_i;
    assign do_init   = rel_i || (in_commit && acc_pzero_q);
    assign do_fault  = in_commit && !acc_pzero_q && (acc_pbad_q || acc_bad_q);
    assign do_latch  = in_commit && !acc_pzero_q && !acc_pbad_q && !acc_bad_q;

    tcfg_shape_store #(
        .N_TILES(N_TILES), .ROW_MAX(ROW_MAX), .BPR_MAX(BPR_MAX),
        .ROW_W(ROW_W), .BPR_W(BPR_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .stage_en (beat_take),
        .beat_idx (cnt_q),
        .beat_data(wr_data_i),
        .commit_en(do_latch),
        .clear_en (do_init),
        .rows_flat(tile_rows_o),
        .bpr_flat (tile_bpr_o)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (rel_i) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (wr_valid_i) begin
                        state_d = ST_LOAD;
                        cnt_d   = BEAT_IDX_W'(1);
                    end else if (rd_req_i) begin
                        state_d = ST_READ;
                        cnt_d   = '0;
                    end
                end
                ST_LOAD: begin
                    if (wr_valid_i) begin
                        if (cnt_q == LAST_BEAT) begin
                            state_d = ST_COMMIT;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                ST_COMMIT: state_d = ST_IDLE;
                ST_READ: begin
                    if (cnt_q == LAST_BEAT) begin
                        state_d = ST_IDLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register and per-image check accumulators
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            cnt_q       <= '0;
            acc_bad_q   <= 1'b0;
            acc_pzero_q <= 1'b0;
            acc_pbad_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (beat_take) begin
                if (cnt_q == '0) begin
                    acc_bad_q   <= beat_bad;
                    acc_pzero_q <= beat_pzero;
                    acc_pbad_q  <= beat_pbad;
                end else begin
                    acc_bad_q <= acc_bad_q | beat_bad;
                end
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q   <= 1'b0;
            zero_q  <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            zero_q  <= do_init;
            fault_q <= do_fault;
            if (do_init)       cfg_q <= 1'b0;
            else if (do_latch) cfg_q <= 1'b1;
        end
    end

    assign cfg_valid_o  = cfg_q;
    assign zero_tiles_o = zero_q;
    assign fault_o      = fault_q;
    assign rd_valid_o   = (state_q == ST_READ);

    // read-back packing of the active copy
    always_comb begin
        rd_data_o = '0;
        if (state_q == ST_READ && cfg_q) begin
            if (cnt_q == '0) rd_data_o[0] = 1'b1;
            for (int t = 0; t < N_TILES; t++) begin
                if (int'(cnt_q) == BPR_BEAT0 + t / 2)
                    rd_data_o[16*(t%2) +: BPR_W] = tile_bpr_o[t*BPR_W +: BPR_W];
                if (int'(cnt_q) == ROW_BEAT0 + t / 4)
                    rd_data_o[8*(t%4) +: ROW_W] = tile_rows_o[t*ROW_W +: ROW_W];
            end
        end
    end

    p_release_inits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rel_i |=> (zero_tiles_o && !cfg_valid_o && tile_rows_o == '0 && tile_bpr_o == '0));
    p_fault_keeps_cfg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (cfg_valid_o == $past(cfg_valid_o) && tile_rows_o == $past(tile_rows_o)
                     && tile_bpr_o == $past(tile_bpr_o)));
    p_pulses_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(fault_o && zero_tiles_o));
    p_cfg_rise_after_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_valid_o) |-> $past(state_q) == ST_COMMIT);
    p_unconf_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && !cfg_valid_o) |-> rd_data_o == '0);
    p_read_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && cnt_q == LAST_BEAT) |=> !rd_valid_o);
endmodule

// File: tb/tile_cfg_unit_bench.sv
module tile_cfg_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 16;
    localparam int RW = 5;
    localparam int BW = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic rd_req = 1'b0;
    logic rel = 1'b0;
    logic rd_valid, cfg_valid, zero_tiles, fault;
    logic [31:0] rd_data;
    logic [NT*RW-1:0] tile_rows;
    logic [NT*BW-1:0] tile_bpr;

    always #(CLK_PERIOD/2) clk = ~clk;

    tile_cfg_unit u_tile_cfg_unit (
        .clk(clk), .rst_n(rst_n), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
        .rd_req_i(rd_req), .rel_i(rel), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
        .cfg_valid_o(cfg_valid), .zero_tiles_o(zero_tiles), .fault_o(fault),
        .tile_rows_o(tile_rows), .tile_bpr_o(tile_bpr)
    );

    int n_tot = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // image under construction
    int img_pal;
    int img_rows [NT];
    int img_bpr  [NT];
    int img_res_pos;   // reserved byte index 1..15, 0 = none
    int img_res_val;
    logic [31:0] img [16];

    // model of the active configuration
    bit m_cfg = 1'b0;
    int m_rows [NT];
    int m_bpr  [NT];
    bit e_fault, e_zero;

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_tot++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic base_img();
        img_pal = 1;
        img_res_pos = 0;
        img_res_val = 0;
        for (int t = 0; t < NT; t++) begin
            img_rows[t] = t + 1;
            img_bpr[t]  = 4 * (t + 1);
        end
    endtask

    task automatic pack_img();
        logic [7:0] bytes [64];
        for (int b = 0; b < 64; b++) bytes[b] = 8'd0;
        bytes[0] = 8'(img_pal);
        if (img_res_pos != 0) bytes[img_res_pos] = 8'(img_res_val);
        for (int t = 0; t < NT; t++) begin
            bytes[16 + 2*t] = 8'(img_bpr[t]);
            bytes[17 + 2*t] = 8'(img_bpr[t] >> 8);
            bytes[48 + t]   = 8'(img_rows[t]);
        end
        for (int i = 0; i < 16; i++)
            img[i] = {bytes[4*i+3], bytes[4*i+2], bytes[4*i+1], bytes[4*i]};
    endtask

    function automatic bit img_ok();
        bit ok = (img_pal == 1) && (img_res_pos == 0 || img_res_val == 0);
        for (int t = 0; t < NT; t++)
            if (img_rows[t] > 16 || img_bpr[t] > 64) ok = 1'b0;
        return ok;
    endfunction

    task automatic model_init();
        m_cfg = 1'b0;
        for (int t = 0; t < NT; t++) begin
            m_rows[t] = 0;
            m_bpr[t]  = 0;
        end
    endtask

    task automatic model_load();
        e_fault = 1'b0;
        e_zero  = 1'b0;
        if (img_pal == 0) begin
            model_init();
            e_zero = 1'b1;
        end else if (img_ok()) begin
            m_cfg = 1'b1;
            for (int t = 0; t < NT; t++) begin
                m_rows[t] = img_rows[t];
                m_bpr[t]  = img_bpr[t];
            end
        end else begin
            e_fault = 1'b1;
        end
    endtask

    task automatic chk_shapes(input string req);
        logic [NT*RW-1:0] er;
        logic [NT*BW-1:0] eb;
        for (int t = 0; t < NT; t++) begin
            er[t*RW +: RW] = RW'(m_rows[t]);
            eb[t*BW +: BW] = BW'(m_bpr[t]);
        end
        chk({req, " cfg"}, 128'(cfg_valid), 128'(m_cfg));
        chk({req, " rows"}, 128'(tile_rows), 128'(er));
        chk({req, " bpr"}, 128'(tile_bpr), 128'(eb));
    endtask

    // sends the image; returns at the negedge after the result edge
    task automatic send(input int gap, input string req);
        pack_img();
        for (int i = 0; i < 16; i++) begin
            if (i > 0)
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk); wr_valid = 1'b0; rd_req = 1'b1;
                end
            @(negedge clk); wr_valid = 1'b1; rd_req = 1'b0; wr_data = img[i];
        end
        @(negedge clk); wr_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        model_load();
        chk({req, " fault"}, 128'(fault), 128'(e_fault));
        chk({req, " zero"}, 128'(zero_tiles), 128'(e_zero));
        chk_shapes(req);
    endtask

    task automatic read_back(input string req);
        @(negedge clk); rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0;
        for (int i = 0; i < 16; i++) begin
            logic [31:0] e = '0;
            if (m_cfg) begin
                if (i == 0) e = 32'd1;
                else if (i >= 4 && i < 12) e = {16'(m_bpr[2*(i-4)+1]), 16'(m_bpr[2*(i-4)])};
                else if (i >= 12) e = {8'(m_rows[4*(i-12)+3]), 8'(m_rows[4*(i-12)+2]),
                                       8'(m_rows[4*(i-12)+1]), 8'(m_rows[4*(i-12)])};
            end
            chk({req, " rd_valid"}, 128'(rd_valid), 128'(1));
            chk({req, " rd_data"}, 128'(rd_data), 128'(e));
            @(negedge clk);
        end
        chk({req, " rd_end"}, 128'(rd_valid), 128'(0));
    endtask

    task automatic release_now(input string req);
        @(negedge clk); rel = 1'b1; wr_valid = 1'b0;
        @(negedge clk); rel = 1'b0;
        model_init();
        chk({req, " zero"}, 128'(zero_tiles), 128'(1));
        chk({req, " fault"}, 128'(fault), 128'(0));
        chk_shapes(req);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_tot++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_tot, n_bad);
            $finish;
        end
    end

    initial begin
        model_init();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cfg", 128'(cfg_valid), 128'(0));
        chk("R1 zero", 128'(zero_tiles), 128'(0));
        chk("R1 fault", 128'(fault), 128'(0));
        chk("R1 rd_valid", 128'(rd_valid), 128'(0));
        chk("R1 rows", 128'(tile_rows), 128'(0));
        chk("R1 bpr", 128'(tile_bpr), 128'(0));
        // R9 read while unconfigured
        read_back("R9 unconf");
        // R2 basic latch and R8 readback
        base_img();
        send(0, "R2 base");
        read_back("R8 base");
        // R6 row count sweep on every tile
        for (int t = 0; t < NT; t++)
            for (int v = 0; v <= 18; v++) begin
                base_img();
                img_rows[t] = v;
                send(0, "R6 rows");
            end
        // R6 bytes-per-row sweep, including upper-byte values
        for (int t = 0; t < NT; t++)
            for (int k = 0; k < 9; k++) begin
                int vals [9] = '{0, 1, 63, 64, 65, 127, 256, 320, 65535};
                base_img();
                img_bpr[t] = vals[k];
                send(0, "R6 bpr");
            end
        read_back("R8 after sweep");
        // R7 reserved bytes
        for (int b = 1; b < 16; b++) begin
            base_img();
            img_res_pos = b;
            img_res_val = 1 << (b % 8);
            send(0, "R7 reserved");
        end
        // R5 and R3 palette sweep
        for (int p = 0; p < 256; p++) begin
            base_img();
            img_rows[p % NT] = (p % 17);
            img_pal = p;
            send(0, (p == 0) ? "R3 pal0" : "R5 palette");
            if (p == 0) begin
                base_img();
                send(0, "R2 reload");
            end
        end
        // R11 palette zero ignores bad fields
        base_img();
        img_pal = 0;
        img_rows[3] = 99;
        img_bpr[5] = 500;
        img_res_pos = 7;
        img_res_val = 8'hff;
        send(0, "R11 pal0 bad fields");
        read_back("R9 after init");
        // R10 gaps with read requests during load
        base_img();
        img_rows[0] = 16;
        img_bpr[15] = 64;
        send(3, "R10 gaps");
        chk("R10 no read", 128'(rd_valid), 128'(0));
        read_back("R8 after gaps");
        // R4 release while configured
        release_now("R4 idle release");
        read_back("R9 after release");
        // R4 release mid-load, then a clean load
        base_img();
        pack_img();
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); wr_valid = 1'b1; wr_data = img[i];
        end
        release_now("R4 mid-load release");
        base_img();
        img_rows[9] = 2;
        send(1, "R4 reload after abort");
        read_back("R8 final");
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end
endmodule